// File: doc/BRIEF.md
# Staggered Output Turn-On Sequencer

This block sits between the latched drive pattern of a multi-channel LED sink driver and its current sources. It spreads the moment at which the outputs start to conduct, so that the supply does not see every channel switch on together. The outputs are arranged as three colour groups of eight positions each. The red, green and blue channels at one position form an index, and they always share the same delay.

Each colour group has its own active-low enable. When the stagger select is low, a group enable that goes low releases index 1 in the first clock edge that samples it low. Each later index then follows one fixed step of `STEP_CYC` clock cycles behind the index before it. When the stagger select is high, all indices of the group are released together. Taking a group enable high blanks that group at once, without waiting for a clock, and drops any turn-on still in progress. The analog delay line and the current sources themselves are not modelled. The step is counted in clock cycles.

Top module: `stagger_turnon_seq`

## Requirements
- R1: While reset is asserted, and after reset until some group enable has been sampled low, every bit of `drv_out` is 0, whatever `pix_in` holds.
- R2: While `grp_en_n[g]` is 1, the eight bits of group g on `drv_out` are 0. This takes effect without waiting for a clock edge.
- R3: With `stag_sel_n` = 0, call edge 0 the first rising clock edge at which `grp_en_n[g]` is sampled 0 after being sampled 1 (or after reset). Index 1 of group g, which is bit `g*8+0`, is released from edge 0 on.
- R4: With stagger active, index i of a group (bit `g*8+i-1`, i = 1..8) is released from edge `(i-1)*STEP_CYC` on. Before that edge its output is 0.
- R5: When several group enables fall at the same edge, the channels that share an index in those groups are released in the same cycle.
- R6: With `stag_sel_n` = 1 at edge 0, all eight indices of the group are released from edge 0.
- R7: Raising a group enable cancels the pending turn-on of that group. A later fall of that enable restarts the sequence from index 1.
- R8: If `stag_sel_n` is sampled 1 at a clock edge while a group is enabled and its sequence is still running, every remaining index of that group is released from that edge.
- R9: A released output equals its `pix_in` bit combinationally, and a bit that is not released is 0. Group 0 is red (bits 7:0), group 1 is green (bits 15:8) and group 2 is blue (bits 23:16).
- R10: Groups are sequenced independently. Each group's delays are counted from the fall of its own enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | NUM_GRP*NUM_IDX (24) | Raw on/off pattern for every channel |
| grp_en_n | input | NUM_GRP (3) | Active-low enable, one per colour group |
| stag_sel_n | input | 1 | Active-low stagger select. 0 staggers the turn-on, 1 releases all indices together |
| drv_out | output | NUM_GRP*NUM_IDX (24) | Gated channel drive |

## Verification
The hardest situations to reach are interactions inside a running sequence. These include an enable that rises and falls again before index 8 is released, a stagger select that flips partway through, and two groups whose sequences are offset by a few cycles. The stimulus reaches each of these from the ports by timing enable and select changes to specific cycles after a fall. A cycle-counting model in the bench tracks the start edge of each group. A step of two cycles is used, so that the step counter and the index shift are both exercised.

// File: rtl/stagger_turnon_pkg.sv
package stagger_turnon_pkg;
  localparam int unsigned DEF_NUM_GRP  = 3;
  localparam int unsigned DEF_NUM_IDX  = 8;
  localparam int unsigned DEF_STEP_CYC = 1;

  function automatic int unsigned step_cnt_w(input int unsigned step);
    return (step < 2) ? 1 : $clog2(step);
  endfunction
endpackage

// File: rtl/stagger_step_timer.sv
module stagger_step_timer #(
  parameter int unsigned STEP_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = stagger_turnon_pkg::step_cnt_w(STEP_CYC);
  localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/stagger_lane.sv
module stagger_lane #(
  parameter int unsigned NUM_IDX  = 8,
  parameter int unsigned STEP_CYC = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_n,
  input  logic               stag_n,
  output logic [NUM_IDX-1:0] rel_mask
);
  localparam logic [NUM_IDX-1:0] ALL_ON  = '1;
  localparam logic [NUM_IDX-1:0] FIRST_ON = NUM_IDX'(1);

  logic en_prev_n;
  logic fall;
  logic full;
  logic run;
  logic tick;

  assign fall = !en_n && en_prev_n;
  assign full = &rel_mask;
  assign run  = !en_n && !stag_n && !fall && !full;

  generate
    if (STEP_CYC <= 1) begin : g_unit_step
      assign tick = run;
    end else begin : g_multi_step
      stagger_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (en_n || fall),
        .run  (run),
        .tick (tick)
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev_n <= 1'b1;
    end else begin
      en_prev_n <= en_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_mask <= '0;
    end else if (en_n) begin
      rel_mask <= '0;
    end else if (fall) begin
      rel_mask <= stag_n ? ALL_ON : FIRST_ON;
    end else if (stag_n) begin
      rel_mask <= ALL_ON;
    end else if (tick) begin
      rel_mask <= {rel_mask[NUM_IDX-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/stagger_gate.sv
module stagger_gate #(
  parameter int unsigned NUM_IDX = 8
) (
  input  logic [NUM_IDX-1:0] raw,
  input  logic [NUM_IDX-1:0] rel_mask,
  input  logic               en_n,
  output logic [NUM_IDX-1:0] gated
);
  assign gated = raw & rel_mask & {NUM_IDX{~en_n}};
endmodule

// File: rtl/stagger_turnon_seq.sv
module stagger_turnon_seq #(
  parameter int unsigned NUM_GRP  = stagger_turnon_pkg::DEF_NUM_GRP,
  parameter int unsigned NUM_IDX  = stagger_turnon_pkg::DEF_NUM_IDX,
  parameter int unsigned STEP_CYC = stagger_turnon_pkg::DEF_STEP_CYC
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_GRP*NUM_IDX-1:0] pix_in,
  input  logic [NUM_GRP-1:0]         grp_en_n,
  input  logic                       stag_sel_n,
  output logic [NUM_GRP*NUM_IDX-1:0] drv_out
);
  localparam int unsigned TOT_CH = NUM_GRP * NUM_IDX;

  logic [TOT_CH-1:0] rel_all;

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      stagger_lane #(.NUM_IDX(NUM_IDX), .STEP_CYC(STEP_CYC)) u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_n    (grp_en_n[g]),
        .stag_n  (stag_sel_n),
        .rel_mask(rel_all[g*NUM_IDX +: NUM_IDX])
      );
      stagger_gate #(.NUM_IDX(NUM_IDX)) u_gate (
        .raw     (pix_in[g*NUM_IDX +: NUM_IDX]),
        .rel_mask(rel_all[g*NUM_IDX +: NUM_IDX]),
        .en_n    (grp_en_n[g]),
        .gated   (drv_out[g*NUM_IDX +: NUM_IDX])
      );
    end
  endgenerate
endmodule

// File: rtl/stagger_turnon_seq_chk.sv
module stagger_turnon_seq_chk #(
  parameter int unsigned NUM_GRP = 3,
  parameter int unsigned NUM_IDX = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_GRP*NUM_IDX-1:0] pix_in,
  input logic [NUM_GRP-1:0]         grp_en_n,
  input logic                       stag_sel_n,
  input logic [NUM_GRP*NUM_IDX-1:0] drv_out
);
  localparam logic [NUM_IDX-1:0] IDX1 = NUM_IDX'(1);

  AST_OUT_WITHIN_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_out & ~pix_in) == '0); // R9

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
      AST_GROUP_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        grp_en_n[g] |-> (drv_out[g*NUM_IDX +: NUM_IDX] == '0)); // R2

      AST_FIRST_INDEX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(grp_en_n[g]) && !stag_sel_n) |=>
        (grp_en_n[g] ||
         drv_out[g*NUM_IDX +: NUM_IDX] == (pix_in[g*NUM_IDX +: NUM_IDX] & IDX1))); // R3

      AST_NO_STAGGER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(grp_en_n[g]) && stag_sel_n) |=>
        (grp_en_n[g] || drv_out[g*NUM_IDX +: NUM_IDX] == pix_in[g*NUM_IDX +: NUM_IDX])); // R6

      AST_SELECT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_en_n[g] && stag_sel_n) |=>
        (grp_en_n[g] || drv_out[g*NUM_IDX +: NUM_IDX] == pix_in[g*NUM_IDX +: NUM_IDX])); // R8
    end
  endgenerate
endmodule

bind stagger_turnon_seq stagger_turnon_seq_chk #(
  .NUM_GRP(NUM_GRP),
  .NUM_IDX(NUM_IDX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_in    (pix_in),
  .grp_en_n  (grp_en_n),
  .stag_sel_n(stag_sel_n),
  .drv_out   (drv_out)
);

// File: tb/sim_stagger_turnon_seq.sv
module sim_stagger_turnon_seq;
  localparam int NG   = 3;
  localparam int NI   = 8;
  localparam int STEP = 2;
  localparam int NCH  = NG * NI;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pix_in = '0;
  logic [NG-1:0]  grp_en_n = '1;
  logic           stag_sel_n = 1'b1;
  logic [NCH-1:0] drv_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit act [NG];
  bit full [NG];
  int st [NG];

  always #5 clk = ~clk;

  stagger_turnon_seq #(.NUM_GRP(NG), .NUM_IDX(NI), .STEP_CYC(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .grp_en_n(grp_en_n),
    .stag_sel_n(stag_sel_n), .drv_out(drv_out)
  );

  // Cycle model: tracks the start edge of every group's sequence
  always @(posedge clk) begin
    cyc = cyc + 1;
    for (int g = 0; g < NG; g++) begin
      if (!rst_n || grp_en_n[g]) begin
        act[g] = 1'b0;
        full[g] = 1'b0;
      end else if (!act[g]) begin
        act[g] = 1'b1;
        st[g] = cyc;
        full[g] = stag_sel_n;
      end else if (stag_sel_n) begin
        full[g] = 1'b1;
      end
    end
  end

  function automatic logic [NCH-1:0] expect_out();
    logic [NCH-1:0] e = '0;
    for (int g = 0; g < NG; g++)
      for (int i = 0; i < NI; i++)
        e[g*NI+i] = !grp_en_n[g] && act[g] && pix_in[g*NI+i] &&
                    (full[g] || (cyc - st[g]) >= i * STEP);
    return e;
  endfunction

  task automatic check(input string tag);
    logic [NCH-1:0] e = expect_out();
    checks++;
    if (drv_out !== e) begin
      failures++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, drv_out, e);
    end
  endtask

  task automatic step_chk(input string tag);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic off_all();
    grp_en_n = '1;
    #1 check("R2");
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: outputs blank during reset, even with enables low
    pix_in = '1;
    grp_en_n = '0;
    repeat (3) @(negedge clk);
    check("R1");
    grp_en_n = '1;
    @(negedge clk);
    rst_n = 1'b1;
    step_chk("R1");

    // Sweep: every group subset, both select values, three patterns
    for (int gm = 1; gm < 8; gm++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 3; p++) begin
          string tag;
          pix_in = (p == 0) ? '1 : (p == 1) ? 24'hA55A3C : 24'($urandom);
          stag_sel_n = s[0];
          grp_en_n = ~gm[2:0];
          for (int k = 0; k < NI * STEP + 2; k++) begin
            if (s == 1) tag = "R6";
            else if (gm == 7) tag = "R5";
            else if (k == 0) tag = "R3";
            else tag = "R4";
            step_chk(tag);
          end
          off_all();
        end
      end
    end

    // R7: cancel midway, then restart from index 1
    pix_in = '1;
    stag_sel_n = 1'b0;
    grp_en_n = 3'b110;
    repeat (5) step_chk("R7");
    grp_en_n = 3'b111;
    #1 check("R7");
    step_chk("R7");
    grp_en_n = 3'b110;
    for (int k = 0; k < NI * STEP + 1; k++) step_chk("R7");
    off_all();

    // R8: select raised partway releases everything left
    grp_en_n = 3'b000;
    repeat (3) step_chk("R8");
    stag_sel_n = 1'b1;
    step_chk("R8");
    stag_sel_n = 1'b0;
    repeat (3) step_chk("R8");

    // R9: released outputs follow the raw pattern combinationally
    pix_in = 24'h0F33C0;
    #1 check("R9");
    pix_in = 24'hF0CC3F;
    #1 check("R9");
    @(negedge clk);
    off_all();

    // R10: groups start at different cycles
    pix_in = '1;
    grp_en_n = 3'b110;
    repeat (3) step_chk("R10");
    grp_en_n = 3'b010;
    repeat (4) step_chk("R10");
    grp_en_n = 3'b000;
    for (int k = 0; k < NI * STEP + 2; k++) step_chk("R10");
    off_all();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule